// File: doc/BRIEF.md
# Iterative 1600-bit Keccak Permutation Engine

This block applies the Keccak-p permutation to a 1600-bit state. It does one full round across the whole state on every clock cycle. The state is held in 25 lanes of 64 bits. The caller loads a state and raises a one-cycle start strobe. The engine then runs either the full 24-round schedule, used for hashing and MAC, or a reduced 12-round schedule, used for authenticated encryption and random-bit generation. When the last round is done it pulses a completion flag. The permuted state stays on the output until the next accepted start.

Each round runs theta, rho, pi, chi and iota as a single combinational stage. A small constant table feeds iota. It keeps seven bits per round and spreads them into the 64-bit round constant. The reduced schedule uses the last twelve constants of the full schedule. Padding, input injection and mode sequencing are handled outside this block.

Top module: `keccak_perm_core`

## Requirements
- R1: After reset, `state_o` is all zeros and `done_o` is low.
- R2: With `mode_i` = 0, the engine applies 24 rounds using round constants 0 to 23. Lane (x, y) occupies bits [64*(x+5y) +: 64], and lane bit 0 is the least significant bit. An all-zero input yields lane 0 = F1258F7940E1DDE7, lane 1 = 84D5CCF933C0478A and lane 24 = EAF1FF7B5CECA249.
- R3: With `mode_i` = 1, the engine applies 12 rounds using round constants 12 to 23 of the full schedule.
- R4: If a start is accepted at clock edge k, `done_o` is high during the cycle after edge k+N, where N is 24 or 12 according to `mode_i`. In that cycle `state_o` holds the permuted state.
- R5: `done_o` is high for exactly one cycle per accepted start.
- R6: While the engine is idle and `start_i` is low, `state_o` does not change.
- R7: A start raised while a permutation is running is ignored. The running result is unaffected and no extra `done_o` pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while idle |
| mode_i | input | 1 | Round count: 0 = 24 rounds, 1 = 12 rounds |
| state_i | input | 1600 | State to permute, lane x+5y at bits 64*(x+5y) |
| state_o | output | 1600 | Current or final permuted state |
| done_o | output | 1 | One-cycle pulse after the final round |

## Verification
On every cycle, the embedded properties check the following. The completion flag never lasts two cycles. The round index stays within the schedule. A start accepted in reduced mode enters the table at index 12. A start that arrives mid-run neither restarts nor stalls the index. The output holds still while the engine is idle.

Only the bench scenarios can show that the bits are correct. These scenarios compare the final state against the published all-zero vector. They also compare it against an independent loop model for both round counts and several input patterns. The bench also measures the exact cycle of completion and shows that an ignored start leaves no trace.

// File: rtl/keccak_pkg.sv
package keccak_pkg;
  localparam int LANE_W    = 64;
  localparam int NUM_LANES = 25;
  localparam int STATE_W   = LANE_W * NUM_LANES;
  localparam int RC_BITS   = $clog2(LANE_W) + 1;

  typedef logic [LANE_W-1:0] lane_t;

  function automatic lane_t rotl(lane_t v, int r);
    return (v << r) | (v >> ((LANE_W - r) % LANE_W));
  endfunction

  // rho offset for lane index x+5y
  function automatic int rho_off(int idx);
    case (idx)
      0: return 0;   1: return 1;   2: return 62;  3: return 28;  4: return 27;
      5: return 36;  6: return 44;  7: return 6;   8: return 55;  9: return 20;
      10: return 3;  11: return 10; 12: return 43; 13: return 25; 14: return 39;
      15: return 41; 16: return 45; 17: return 15; 18: return 21; 19: return 8;
      20: return 18; 21: return 2;  22: return 61; 23: return 56; 24: return 14;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/keccak_rc_rom.sv
module keccak_rc_rom
  import keccak_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx_i,
  output lane_t            rc_o
);
  logic [RC_BITS-1:0] packed_rc;

  // bit j of packed_rc lands on lane bit 2^j-1
  always_comb begin
    case (idx_i)
      5'd0:  packed_rc = 7'h01;
      5'd1:  packed_rc = 7'h1a;
      5'd2:  packed_rc = 7'h5e;
      5'd3:  packed_rc = 7'h70;
      5'd4:  packed_rc = 7'h1f;
      5'd5:  packed_rc = 7'h21;
      5'd6:  packed_rc = 7'h79;
      5'd7:  packed_rc = 7'h55;
      5'd8:  packed_rc = 7'h0e;
      5'd9:  packed_rc = 7'h0c;
      5'd10: packed_rc = 7'h35;
      5'd11: packed_rc = 7'h26;
      5'd12: packed_rc = 7'h3f;
      5'd13: packed_rc = 7'h4f;
      5'd14: packed_rc = 7'h5d;
      5'd15: packed_rc = 7'h53;
      5'd16: packed_rc = 7'h52;
      5'd17: packed_rc = 7'h48;
      5'd18: packed_rc = 7'h16;
      5'd19: packed_rc = 7'h66;
      5'd20: packed_rc = 7'h79;
      5'd21: packed_rc = 7'h58;
      5'd22: packed_rc = 7'h21;
      5'd23: packed_rc = 7'h74;
      default: packed_rc = '0;
    endcase
  end

  always_comb begin
    rc_o = '0;
    for (int j = 0; j < RC_BITS; j++) rc_o[(1 << j) - 1] = packed_rc[j];
  end
endmodule

// File: rtl/keccak_round.sv
module keccak_round
  import keccak_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  input  lane_t              rc_i,
  output logic [STATE_W-1:0] state_o
);
  lane_t a [NUM_LANES];
  lane_t b [NUM_LANES];
  lane_t e [NUM_LANES];
  lane_t c [5];
  lane_t d [5];

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_unpack
    assign a[i] = state_i[i*LANE_W +: LANE_W];
  end

  for (genvar x = 0; x < 5; x++) begin : g_theta
    assign c[x] = a[x] ^ a[x+5] ^ a[x+10] ^ a[x+15] ^ a[x+20];
    assign d[x] = c[(x+4)%5] ^ rotl(c[(x+1)%5], 1);
  end

  for (genvar x = 0; x < 5; x++) begin : g_col
    for (genvar y = 0; y < 5; y++) begin : g_row
      localparam int SRC = x + 5*y;
      localparam int DST = y + 5*((2*x + 3*y) % 5);
      assign b[DST] = rotl(a[SRC] ^ d[x], rho_off(SRC));
      assign e[SRC] = b[SRC] ^ (~b[(x+1)%5 + 5*y] & b[(x+2)%5 + 5*y]);
    end
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_pack
    if (i == 0) begin : g_iota
      assign state_o[i*LANE_W +: LANE_W] = e[i] ^ rc_i;
    end else begin : g_pass
      assign state_o[i*LANE_W +: LANE_W] = e[i];
    end
  end
endmodule

// File: rtl/keccak_ctrl.sv
module keccak_ctrl #(
  parameter int FULL_ROUNDS    = 24,
  parameter int REDUCED_ROUNDS = 12,
  parameter int IDX_W          = $clog2(FULL_ROUNDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  output logic             load_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FULL_ROUNDS - 1);
  localparam logic [IDX_W-1:0] FIRST_RED = IDX_W'(FULL_ROUNDS - REDUCED_ROUNDS);

  logic             busy_q, done_q;
  logic [IDX_W-1:0] idx_q;

  assign load_o = start_i & ~busy_q;
  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        idx_q  <= mode_i ? FIRST_RED : '0;
      end else if (busy_q) begin
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R4
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> idx_q <= LAST_IDX);

  // R3
  reduced_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q && mode_i) |=> (busy_q && idx_q == FIRST_RED));

  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && idx_q != LAST_IDX) |=> (busy_q && idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/keccak_perm_core.sv
module keccak_perm_core
  import keccak_pkg::*;
#(
  parameter int FULL_ROUNDS    = 24,
  parameter int REDUCED_ROUNDS = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               mode_i,
  input  logic [STATE_W-1:0] state_i,
  output logic [STATE_W-1:0] state_o,
  output logic               done_o
);
  localparam int IDX_W = $clog2(FULL_ROUNDS);

  logic               load, busy;
  logic [IDX_W-1:0]   idx;
  lane_t              rc;
  logic [STATE_W-1:0] state_q, state_nxt;

  keccak_ctrl #(
    .FULL_ROUNDS   (FULL_ROUNDS),
    .REDUCED_ROUNDS(REDUCED_ROUNDS),
    .IDX_W         (IDX_W)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .mode_i (mode_i),
    .load_o (load),
    .busy_o (busy),
    .idx_o  (idx),
    .done_o (done_o)
  );

  keccak_rc_rom #(.IDX_W(IDX_W)) u_rc (
    .idx_i(idx),
    .rc_o (rc)
  );

  keccak_round u_round (
    .state_i(state_q),
    .rc_i   (rc),
    .state_o(state_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= '0;
    else if (load)  state_q <= state_i;
    else if (busy)  state_q <= state_nxt;
  end

  assign state_o = state_q;

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> $stable(state_o));
endmodule

// File: tb/tb_keccak_perm_core.sv
module tb_keccak_perm_core;
  localparam int SW = 1600;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [SW-1:0] state_i = '0;
  logic [SW-1:0] state_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [SW-1:0] st;
    int            due;
    int            req;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  keccak_perm_core dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .mode_i (mode_i),
    .state_i(state_i),
    .state_o(state_o),
    .done_o (done_o)
  );

  function automatic bit lfsr_bit(int t);
    logic [8:0] r;
    logic [7:0] s = 8'h01;
    for (int i = 0; i < t % 255; i++) begin
      r = {s, 1'b0};
      if (r[8]) r = r ^ 9'h171;
      s = r[7:0];
    end
    return s[0];
  endfunction

  function automatic logic [63:0] rc_lane(int rnd);
    logic [63:0] v = '0;
    for (int j = 0; j < 7; j++) v[(1 << j) - 1] = lfsr_bit(j + 7*rnd);
    return v;
  endfunction

  function automatic logic [63:0] rl(logic [63:0] v, int r);
    return (r == 0) ? v : ((v << r) | (v >> (64 - r)));
  endfunction

  function automatic logic [SW-1:0] ref_perm(logic [SW-1:0] s, int first);
    logic [63:0] a [25];
    logic [63:0] b [25];
    logic [63:0] c [5];
    int rot [25];
    int px, py, nx;
    logic [SW-1:0] o;
    for (int i = 0; i < 25; i++) begin a[i] = s[i*64 +: 64]; rot[i] = 0; end
    px = 1; py = 0;
    for (int t = 0; t < 24; t++) begin
      rot[px + 5*py] = ((t+1)*(t+2)/2) % 64;
      nx = py; py = (2*px + 3*py) % 5; px = nx;
    end
    for (int r = first; r < 24; r++) begin
      for (int x = 0; x < 5; x++) c[x] = a[x]^a[x+5]^a[x+10]^a[x+15]^a[x+20];
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          a[x+5*y] = a[x+5*y] ^ c[(x+4)%5] ^ rl(c[(x+1)%5], 1);
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          b[y + 5*((2*x+3*y)%5)] = rl(a[x+5*y], rot[x+5*y]);
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          a[x+5*y] = b[x+5*y] ^ (~b[(x+1)%5+5*y] & b[(x+2)%5+5*y]);
      a[0] = a[0] ^ rc_lane(r);
    end
    for (int i = 0; i < 25; i++) o[i*64 +: 64] = a[i];
    return o;
  endfunction

  task automatic check(bit ok, string req, logic [SW-1:0] act, logic [SW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // driver: push expectation, pulse start
  task automatic run_perm(logic [SW-1:0] st, bit md, int req);
    exp_t it;
    drain();
    it.st  = ref_perm(st, md ? 12 : 0);
    it.due = cyc + 1 + (md ? 12 : 24);
    it.req = req;
    exp_q.push_back(it);
    state_i = st;
    mode_i  = md;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    state_i = '0;
  endtask

  // monitor
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      if (done_o && prev_done)
        check(1'b0, "R5 done wider than one cycle", SW'(1), SW'(0));
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected done", SW'(1), SW'(0));
        end else begin
          exp_t it;
          it = exp_q.pop_front();
          check(state_o == it.st, $sformatf("R%0d result", it.req), state_o, it.st);
          // R4 completion cycle
          check(cyc == it.due, "R4 latency", SW'(cyc), SW'(it.due));
        end
      end
      prev_done <= done_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] pat, held;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(state_o == '0, "R1 state", state_o, '0);
    check(done_o == 1'b0, "R1 done", SW'(done_o), SW'(0));
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 zero state, full schedule, known vector
    run_perm('0, 1'b0, 2);
    drain();
    check(state_o[0*64 +: 64] == 64'hF1258F7940E1DDE7, "R2 lane0",
          SW'(state_o[0 +: 64]), SW'(64'hF1258F7940E1DDE7));
    check(state_o[1*64 +: 64] == 64'h84D5CCF933C0478A, "R2 lane1",
          SW'(state_o[64 +: 64]), SW'(64'h84D5CCF933C0478A));
    check(state_o[24*64 +: 64] == 64'hEAF1FF7B5CECA249, "R2 lane24",
          SW'(state_o[24*64 +: 64]), SW'(64'hEAF1FF7B5CECA249));

    // R6 output held while idle
    held = state_o;
    repeat (10) @(negedge clk);
    check(state_o == held, "R6 hold", state_o, held);

    // R3 reduced schedule on zero and patterned states
    run_perm('0, 1'b1, 3);
    for (int i = 0; i < 25; i++) pat[i*64 +: 64] = {32'(i) * 32'h9E3779B9, 32'hA5A5_0000 | 32'(i)};
    run_perm(pat, 1'b1, 3);
    run_perm(pat, 1'b0, 2);
    run_perm(~pat, 1'b0, 2);
    pat = '0;
    pat[7*64] = 1'b1;
    run_perm(pat, 1'b1, 3);

    // R7 start while busy is ignored
    run_perm(~pat, 1'b0, 7);
    repeat (5) @(negedge clk);
    state_i = {25{64'h0123456789ABCDEF}};
    mode_i  = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    drain();
    held = state_o;
    repeat (30) @(negedge clk);
    check(state_o == held, "R7 no restart after ignored start", state_o, held);

    drain();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule